// File: doc/BRIEF.md
# Multichannel CIC Decimator

This block is a cascaded integrator-comb decimator built only from adders, subtractors and registers. Signed samples arrive on a valid/ready stream. Consecutive accepted samples belong to channels 0, 1, ... CHANNELS-1 in turn, and the cycle then starts again. Every channel keeps its own integrator state, decimation phase and comb delay lines, so one shared datapath serves all channels.

Each input passes through N_STAGES pipelined integrators, one stage per clock. An integrator works in wraparound arithmetic at the full internal width FULL_W = IN_W + N_STAGES*ceil(log2(RATE*DIFF_DLY)). For each channel, every RATE-th integrated value goes on to N_STAGES comb stages, and each comb subtracts the value it saw DIFF_DLY low-rate samples earlier. A registered quantizer then reduces the FULL_W result to OUT_W bits. The `quant_mode` input selects how. Each output carries its channel index and flags that mark the first and the last channel of a group.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high, `s_ready` and `m_valid` are low. From the first clock edge after `rst` falls, `s_ready` stays high.
- R2: A channel produces exactly one output for every RATE samples it accepts: after its RATE-th, 2*RATE-th, and so on. No output appears at any other time.
- R3: Let y be the channel's input sequence convolved with N_STAGES cascaded boxcars of length RATE*DIFF_DLY and sampled at the decimation points. With `quant_mode` = 0 (truncate), `m_data` is floor(y / 2^(FULL_W-OUT_W)).
- R4: With `quant_mode` = 1 (convergent), `m_data` is y / 2^(FULL_W-OUT_W), rounded to the nearest integer. An exact half goes to the even result. A positive overflow clamps to 2^(OUT_W-1)-1.
- R5: With `quant_mode` = 2 (round up), `m_data` is floor(y / 2^(FULL_W-OUT_W) + 1/2), with the same clamp as R4.
- R6: With `quant_mode` = 3 (saturate), `m_data` is y itself, without scaling, when y fits in OUT_W signed bits. Otherwise it is 2^(OUT_W-1)-1 for positive y and -2^(OUT_W-1) for negative y.
- R7: `m_chan` gives the channel of each output, and outputs of one decimation point leave in ascending channel order. `m_first` is high exactly when `m_chan` = 0, and `m_last` is high exactly when `m_chan` = CHANNELS-1.
- R8: A channel's outputs depend only on that channel's samples.
- R9: Reset clears every integrator, comb delay line and decimation counter. After reset the outputs match a filter that has seen no input before.
- R10: Cycles with `s_valid` low are not accepted. They do not advance the channel sequence and do not change any channel's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quant_mode | input | 2 | Output reduction: 0 truncate, 1 convergent, 2 round up, 3 saturate |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block accepts a sample |
| s_data | input | IN_W | Signed input sample |
| m_valid | output | 1 | Output sample valid |
| m_data | output | OUT_W | Signed quantized output |
| m_chan | output | max(1,ceil(log2(CHANNELS))) | Channel of the output |
| m_first | output | 1 | Output belongs to channel 0 |
| m_last | output | 1 | Output belongs to the last channel |

## Verification
An impulse on channel 0 alone exposes the cascaded-boxcar response term by term, and it shows whether the silent channel picks up anything from its neighbour. Steps with different levels per channel separate the DC gain of each channel and catch mixed-up channel state. Random full-scale samples, some with idle cycles between them, land on exact halves and overflow often enough to tell the four reduction modes apart. They also show whether idle cycles disturb the decimation phase. A fresh reset after a noisy run, followed by an impulse, shows whether any state survives the reset.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    QM_TRUNC = 2'd0,
    QM_CONV  = 2'd1,
    QM_RUP   = 2'd2,
    QM_SAT   = 2'd3
  } qmode_e;

  function automatic int growth_bits(input int stages, input int rate, input int dly);
    return stages * $clog2(rate * dly);
  endfunction
endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int W        = 14,
  parameter int CH_W     = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [CH_W-1:0] in_ch,
  input  logic [W-1:0]    in_data,
  output logic            out_valid,
  output logic [CH_W-1:0] out_ch,
  output logic [W-1:0]    out_data
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic            v_in, pv;
    logic [CH_W-1:0] c_in, pc;
    logic [W-1:0]    d_in, pd, sum;
    logic [W-1:0]    acc [CHANNELS];

    if (s == 0) begin : g_head
      assign v_in = in_valid;
      assign c_in = in_ch;
      assign d_in = in_data;
    end else begin : g_link
      assign v_in = g_st[s-1].pv;
      assign c_in = g_st[s-1].pc;
      assign d_in = g_st[s-1].pd;
    end

    assign sum = acc[c_in] + d_in;

    always_ff @(posedge clk) begin
      if (rst) begin
        pv <= 1'b0;
        pc <= '0;
        pd <= '0;
        for (int c = 0; c < CHANNELS; c++) acc[c] <= '0;
      end else begin
        pv <= v_in;
        if (v_in) begin
          acc[c_in] <= sum;
          pd        <= sum;
          pc        <= c_in;
        end
      end
    end
  end

  assign out_valid = g_st[STAGES-1].pv;
  assign out_ch    = g_st[STAGES-1].pc;
  assign out_data  = g_st[STAGES-1].pd;
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int DIFF_DLY = 1,
  parameter int W        = 14,
  parameter int CH_W     = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [CH_W-1:0] in_ch,
  input  logic [W-1:0]    in_data,
  output logic            out_valid,
  output logic [CH_W-1:0] out_ch,
  output logic [W-1:0]    out_data
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic            v_in, pv;
    logic [CH_W-1:0] c_in, pc;
    logic [W-1:0]    d_in, pd;
    logic [W-1:0]    dl [CHANNELS][DIFF_DLY];

    if (s == 0) begin : g_head
      assign v_in = in_valid;
      assign c_in = in_ch;
      assign d_in = in_data;
    end else begin : g_link
      assign v_in = g_st[s-1].pv;
      assign c_in = g_st[s-1].pc;
      assign d_in = g_st[s-1].pd;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pv <= 1'b0;
        pc <= '0;
        pd <= '0;
        for (int c = 0; c < CHANNELS; c++)
          for (int k = 0; k < DIFF_DLY; k++) dl[c][k] <= '0;
      end else begin
        pv <= v_in;
        if (v_in) begin
          pd        <= d_in - dl[c_in][DIFF_DLY-1];
          pc        <= c_in;
          dl[c_in][0] <= d_in;
          for (int k = 1; k < DIFF_DLY; k++) dl[c_in][k] <= dl[c_in][k-1];
        end
      end
    end
  end

  assign out_valid = g_st[STAGES-1].pv;
  assign out_ch    = g_st[STAGES-1].pc;
  assign out_data  = g_st[STAGES-1].pd;
endmodule

// File: rtl/cic_quantizer.sv
module cic_quantizer
  import cic_pkg::*;
#(
  parameter int FULL_W   = 14,
  parameter int OUT_W    = 10,
  parameter int CHANNELS = 2,
  parameter int CH_W     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [FULL_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic [CH_W-1:0]   out_ch,
  output logic              out_first,
  output logic              out_last
);
  localparam int DROP = FULL_W - OUT_W;
  localparam logic [OUT_W-1:0] MINV = OUT_W'(1) << (OUT_W - 1);
  localparam logic [OUT_W-1:0] MAXV = ~MINV;

  logic [OUT_W-1:0] q;

  if (DROP > 0) begin : g_reduce
    localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP - 1);
    qmode_e           qm;
    logic [OUT_W-1:0] hi;
    logic [DROP-1:0]  lo;
    logic             inc, fits;
    logic [OUT_W:0]   rsum;
    logic [DROP:0]    top;

    assign qm   = qmode_e'(mode);
    assign hi   = in_data[FULL_W-1:DROP];
    assign lo   = in_data[DROP-1:0];
    assign top  = in_data[FULL_W-1:OUT_W-1];
    assign fits = (&top) | ~(|top);

    always_comb begin
      inc = 1'b0;
      case (qm)
        QM_CONV: inc = (lo > HALF) | ((lo == HALF) & hi[0]);
        QM_RUP:  inc = lo[DROP-1];
        default: inc = 1'b0;
      endcase
      rsum = {hi[OUT_W-1], hi} + (OUT_W+1)'(inc);
      if (qm == QM_SAT)
        q = fits ? in_data[OUT_W-1:0] : (in_data[FULL_W-1] ? MINV : MAXV);
      else if (rsum[OUT_W] != rsum[OUT_W-1])
        q = MAXV;
      else
        q = rsum[OUT_W-1:0];
    end
  end else begin : g_pass
    assign q = in_data[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ch    <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= q;
        out_ch    <= in_ch;
        out_first <= (in_ch == '0);
        out_last  <= (in_ch == CH_W'(CHANNELS - 1));
      end
    end
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int N_STAGES = 3,
  parameter int RATE     = 4,
  parameter int DIFF_DLY = 1,
  parameter int IN_W     = 8,
  parameter int OUT_W    = 10,
  parameter int CHANNELS = 2,
  localparam int FULL_W  = IN_W + growth_bits(N_STAGES, RATE, DIFF_DLY),
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       quant_mode,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [IN_W-1:0]  s_data,
  output logic             m_valid,
  output logic [OUT_W-1:0] m_data,
  output logic [CH_W-1:0]  m_chan,
  output logic             m_first,
  output logic             m_last
);
  localparam int CNT_W = $clog2(RATE);

  logic              take;
  logic [CH_W-1:0]   in_ch;
  logic [FULL_W-1:0] x_ext;

  logic              iv;
  logic [CH_W-1:0]   ic;
  logic [FULL_W-1:0] id;

  logic              dv;
  logic [CH_W-1:0]   dc;
  logic [FULL_W-1:0] dd;
  logic [CNT_W-1:0]  phase [CHANNELS];

  logic              cv;
  logic [CH_W-1:0]   cc;
  logic [FULL_W-1:0] cd;

  assign take  = s_valid & s_ready;
  assign x_ext = {{(FULL_W-IN_W){s_data[IN_W-1]}}, s_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ready <= 1'b0;
      in_ch   <= '0;
    end else begin
      s_ready <= 1'b1;
      if (take) in_ch <= (in_ch == CH_W'(CHANNELS - 1)) ? '0 : in_ch + 1'b1;
    end
  end

  cic_integ_chain #(
    .STAGES(N_STAGES), .CHANNELS(CHANNELS), .W(FULL_W), .CH_W(CH_W)
  ) u_integ (
    .clk(clk), .rst(rst),
    .in_valid(take), .in_ch(in_ch), .in_data(x_ext),
    .out_valid(iv), .out_ch(ic), .out_data(id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dv <= 1'b0;
      dc <= '0;
      dd <= '0;
      for (int c = 0; c < CHANNELS; c++) phase[c] <= '0;
    end else begin
      dv <= 1'b0;
      if (iv) begin
        if (phase[ic] == CNT_W'(RATE - 1)) begin
          phase[ic] <= '0;
          dv        <= 1'b1;
          dc        <= ic;
          dd        <= id;
        end else begin
          phase[ic] <= phase[ic] + 1'b1;
        end
      end
    end
  end

  cic_comb_chain #(
    .STAGES(N_STAGES), .CHANNELS(CHANNELS), .DIFF_DLY(DIFF_DLY), .W(FULL_W), .CH_W(CH_W)
  ) u_comb (
    .clk(clk), .rst(rst),
    .in_valid(dv), .in_ch(dc), .in_data(dd),
    .out_valid(cv), .out_ch(cc), .out_data(cd)
  );

  cic_quantizer #(
    .FULL_W(FULL_W), .OUT_W(OUT_W), .CHANNELS(CHANNELS), .CH_W(CH_W)
  ) u_quant (
    .clk(clk), .rst(rst), .mode(quant_mode),
    .in_valid(cv), .in_ch(cc), .in_data(cd),
    .out_valid(m_valid), .out_data(m_data), .out_ch(m_chan),
    .out_first(m_first), .out_last(m_last)
  );
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int CHANNELS = 2,
  parameter int CH_W     = 1
) (
  input logic            clk,
  input logic            rst,
  input logic            s_ready,
  input logic            m_valid,
  input logic [CH_W-1:0] m_chan,
  input logic            m_first,
  input logic            m_last
);
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    !rst |=> s_ready);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !m_valid);

  a_r2_no_repeat_channel: assert property (@(posedge clk) disable iff (rst)
    (m_valid && $past(m_valid)) |-> (m_chan != $past(m_chan)));

  a_r7_chan_range: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (int'(m_chan) < CHANNELS));

  a_r7_first_flag: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_first == (m_chan == '0)));

  a_r7_last_flag: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_last == (int'(m_chan) == CHANNELS - 1)));
endmodule

bind cic_decim cic_decim_chk #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .m_valid(m_valid),
  .m_chan(m_chan), .m_first(m_first), .m_last(m_last)
);

// File: tb/test_cic_decim.sv
module test_cic_decim;
  localparam int N    = 3;
  localparam int R    = 4;
  localparam int M    = 1;
  localparam int IW   = 8;
  localparam int OW   = 10;
  localparam int C    = 2;
  localparam int FW   = IW + N * $clog2(R * M);
  localparam int DROP = FW - OW;
  localparam int CW   = (C > 1) ? $clog2(C) : 1;
  localparam int L    = N * (R * M - 1) + 1;
  localparam int OMAX = (1 << (OW - 1)) - 1;
  localparam int OMIN = -(1 << (OW - 1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    quant_mode = 2'd0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [IW-1:0] s_data = '0;
  logic          m_valid;
  logic [OW-1:0] m_data;
  logic [CW-1:0] m_chan;
  logic          m_first, m_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int h [L];
  int hist [C][L];
  int fed [C];
  int got [C];
  int exp_val [$];
  int exp_ch [$];
  string tag = "R3";

  always #2.5 clk = ~clk;

  cic_decim #(.N_STAGES(N), .RATE(R), .DIFF_DLY(M), .IN_W(IW), .OUT_W(OW), .CHANNELS(C))
  i_cic_decim (
    .clk(clk), .rst(rst), .quant_mode(quant_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_data(m_data), .m_chan(m_chan),
    .m_first(m_first), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clampi(input int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  function automatic int quant(input int y, input int mode);
    int q, rem, half;
    q    = y >>> DROP;
    rem  = y - (q << DROP);
    half = 1 << (DROP - 1);
    case (mode)
      0: return q;
      1: return clampi(q + (((rem > half) || (rem == half && (q & 1) != 0)) ? 1 : 0));
      2: return clampi(q + ((rem >= half) ? 1 : 0));
      default: return clampi(y);
    endcase
  endfunction

  task automatic ref_push(input int ch, input int x);
    int y;
    for (int k = L - 1; k > 0; k--) hist[ch][k] = hist[ch][k-1];
    hist[ch][0] = x;
    fed[ch]++;
    if (fed[ch] % R == 0) begin
      y = 0;
      for (int k = 0; k < L; k++) y += h[k] * hist[ch][k];
      exp_val.push_back(quant(y, int'(quant_mode)));
      exp_ch.push_back(ch);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_valid) begin
      if (exp_val.size() == 0) begin
        check(1'b0, "R2", int'(m_chan), -1);
      end else begin
        int ev, ec;
        ev = exp_val.pop_front();
        ec = exp_ch.pop_front();
        check($signed(m_data) == ev, tag, int'($signed(m_data)), ev);
        check(int'(m_chan) == ec, "R7", int'(m_chan), ec);
        check(m_first == (ec == 0) && m_last == (ec == C - 1), "R7",
              int'({m_first, m_last}), int'({ec == 0, ec == C - 1}));
        got[int'(m_chan)]++;
      end
    end
  end

  // pat: 0 impulse on channel 0 only, 1 per-channel step, 2 random full scale
  task automatic run_phase(input int mode, input int pat, input int groups,
                           input int gap_pct, input string t);
    int ch, x, total;
    rst = 1'b1;
    s_valid = 1'b0;
    quant_mode = 2'(mode);
    tag = t;
    repeat (3) @(negedge clk);
    check(s_ready == 1'b0 && m_valid == 1'b0, "R1", int'({s_ready, m_valid}), 0);
    exp_val.delete();
    exp_ch.delete();
    for (int c = 0; c < C; c++) begin
      fed[c] = 0;
      got[c] = 0;
      for (int k = 0; k < L; k++) hist[c][k] = 0;
    end
    rst = 1'b0;
    @(negedge clk);
    check(s_ready == 1'b1, "R1", int'(s_ready), 1);
    ch = 0;
    total = groups * R * C;
    for (int i = 0; i < total; i++) begin
      while (int'($urandom % 100) < gap_pct) begin
        s_valid = 1'b0;
        s_data  = IW'($urandom);
        @(negedge clk);
      end
      case (pat)
        0: x = (ch == 0 && i == 0) ? 100 : 0;
        1: x = (ch == 0) ? 37 : -55;
        default: x = int'($urandom % 255) - 127;
      endcase
      s_valid = 1'b1;
      s_data  = IW'(x);
      ref_push(ch, x);
      ch = (ch + 1) % C;
      @(negedge clk);
    end
    s_valid = 1'b0;
    repeat (2 * N + 10) @(negedge clk);
    check(exp_val.size() == 0, "R2", exp_val.size(), 0);
    for (int c = 0; c < C; c++) check(got[c] == groups, "R2", got[c], groups);
  endtask

  initial begin
    int tmp [L];
    int len;
    void'($urandom(32'h5eed_c1c0));
    for (int k = 0; k < L; k++) h[k] = 0;
    h[0] = 1;
    len = 1;
    for (int s = 0; s < N; s++) begin
      for (int k = 0; k < L; k++) begin
        tmp[k] = 0;
        for (int j = 0; j < R * M; j++) if (k - j >= 0) tmp[k] += h[k-j];
      end
      len += R * M - 1;
      for (int k = 0; k < L; k++) h[k] = (k < len) ? tmp[k] : 0;
    end

    run_phase(0, 0, 6, 0,  "R3/R8");
    run_phase(1, 1, 6, 0,  "R4");
    run_phase(1, 2, 40, 0, "R4");
    run_phase(2, 2, 40, 30, "R5/R10");
    run_phase(3, 2, 40, 0, "R6");
    run_phase(3, 1, 6, 0,  "R6");
    run_phase(0, 0, 6, 0,  "R9");
    run_phase(0, 2, 40, 40, "R3/R10");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule